// File: doc/BRIEF.md
# Floating-Point to Fixed-Point Aligner

This block takes one IEEE-754 single-precision number per cycle and turns it into a signed two's-complement word. The word is laid out on a fixed-point grid. The grid is chosen by two bit-weight parameters: `MSB_W`, the weight of the top bit of the word, and `LSB_W`, the weight of its bottom bit. The word feeds a wide fixed-point accumulator that sits elsewhere. Because every input lands on the same grid, that accumulator can add values with a plain integer adder in one cycle.

Conversion has four steps:
- Decode the exponent, restoring the implicit leading one for normal numbers and using a zero leading bit for subnormals.
- Compute how far the 24-bit significand must move so that each of its bits sits at its true weight.
- Shift the significand, dropping any bits that fall below `LSB_W`.
- Negate the shifted magnitude if the sign bit is set.

Values that do not fit on the grid produce a zero word with a flag raised. Infinities and NaNs are treated the same way.

The block is a two-stage pipeline. It accepts one input every cycle and returns each result exactly two cycles later, with a valid bit alongside it.

Top module: `flt2fix_align`

## Requirements
- R1: The output word is `MSB_W - LSB_W + 1` bits wide (52 with the defaults `MSB_W = 1`, `LSB_W = -50`). Bit i carries weight 2^(LSB_W + i). For a positive in-range input x that is a multiple of 2^LSB_W, the word equals x * 2^(-LSB_W) as an unsigned integer.
- R2: `outValid` is high exactly two rising edges after `inValid` was sampled high. Inputs on consecutive cycles give results on consecutive cycles, in order. Idle gaps in the input give matching gaps in the output.
- R3: For an input with sign bit 31 set, the word is the two's-complement negation of the word that the same magnitude would produce. A non-negative input never gives a word whose top bit is set.
- R4: An input whose exponent field (bits 30:23) is zero is a subnormal. It has no hidden bit, and its fraction LSB weighs 2^-149. With the default grid, every subnormal lies below `LSB_W` and yields an all-zero word with no flag.
- R5: Significand bits whose weight falls below `LSB_W` are dropped. The magnitude is truncated toward zero before any negation. For example, ±1.5 * 2^-50 yields +1 or -1, and 2^-51 yields 0.
- R6: If the exponent field is all ones (infinity or NaN), or the input magnitude is 2^MSB_W or larger, `outOvf` is 1 and the word is zero. This includes exactly -2^MSB_W. Otherwise `outOvf` is 0.
- R7: +0 and -0 both yield an all-zero word with `outOvf` at 0.
- R8: While `rstN` is low and right after it is released, `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Marks `inData` as a value to convert |
| inData | input | 32 | Single-precision input: bit 31 sign, bits 30:23 exponent, bits 22:0 fraction |
| outValid | output | 1 | Marks `outData` and `outOvf` as a result |
| outData | output | MSB_W-LSB_W+1 | Aligned two's-complement fixed-point word |
| outOvf | output | 1 | Input was out of range, infinite or NaN; the word is zero |

## Verification
The bench aims at the edges of the grid.

At the top edge, it drives the largest in-range value just under 2.0 and exactly ±2.0. A wrong exponent compare would either wrap these values into a negative word or raise the flag one binade too early.

At the bottom edge, it drives 2^-50, ±1.5 * 2^-50, 2^-51 and subnormals. An off-by-one shift offset, or a hidden bit left set on subnormals, shows up here as a value doubled, halved or made non-zero. Rounding instead of truncating before the negation also shows up here, as -2 in place of -1.

Signed zeros, infinities and NaN check that the flag and the zeroed word agree. Back-to-back and gapped streams of varied exponents check ordering and the two-cycle latency against a real-number model.

// File: rtl/flt2fix_pkg.sv
package flt2fix_pkg;

  // Load strobes issued by the control to each pipeline stage
  typedef struct packed {
    logic s1Load;
    logic s2Load;
  } stageStrobe_t;

endpackage

// File: rtl/flt2fix_ctrl.sv
module flt2fix_ctrl
  import flt2fix_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t stb,
  output logic         outValid
);

  logic s1Vld;
  logic s2Vld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Vld <= 1'b0;
      s2Vld <= 1'b0;
    end else begin
      s1Vld <= inValid;
      s2Vld <= s1Vld;
    end
  end

  always_comb begin
    stb.s1Load = inValid;
    stb.s2Load = s1Vld;
  end

  assign outValid = s2Vld;

  // R2
  vld_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> s1Vld);

  // R2
  vld_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    s1Vld |=> outValid);

  // R2
  vld_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !s1Vld |=> !outValid);

endmodule

// File: rtl/flt2fix_dp.sv
module flt2fix_dp
  import flt2fix_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MSB_W  = 1,
  parameter int LSB_W  = -50,
  localparam int IN_W  = 1 + EXP_W + FRAC_W,
  localparam int OUT_W = MSB_W - LSB_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobe_t     stb,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData,
  output logic             outOvf
);

  localparam int SIG_W     = FRAC_W + 1;
  localparam int BIAS      = (2 ** (EXP_W - 1)) - 1;
  localparam int SH_W      = $clog2(OUT_W);
  localparam int WIDE_W    = OUT_W + SIG_W;
  // shift that puts the significand LSB at its weight, counted from the
  // bottom of a buffer that keeps SIG_W guard positions below the grid
  localparam int SHIFT_OFS = SIG_W - BIAS - FRAC_W - LSB_W;
  localparam int OVF_EXP   = BIAS + MSB_W;

  // ---------------- stage 1: decode ----------------
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              signBit;
  logic              isSub;
  logic              isMaxExp;
  int                effExp;
  int                shInt;
  logic              ovfNext;
  logic              killNext;
  logic [SH_W-1:0]   shNext;

  always_comb begin
    signBit   = inData[IN_W-1];
    expField  = inData[FRAC_W +: EXP_W];
    fracField = inData[FRAC_W-1:0];
    isSub     = (expField == '0);
    isMaxExp  = &expField;
    effExp    = isSub ? 1 : int'(expField);
    shInt     = effExp + SHIFT_OFS;
    ovfNext   = isMaxExp || (int'(expField) >= OVF_EXP);
    killNext  = ovfNext || (shInt < 0);
    shNext    = killNext ? '0 : SH_W'(shInt);
  end

  logic             s1Sign;
  logic [SIG_W-1:0] s1Sig;
  logic [SH_W-1:0]  s1Sh;
  logic             s1Kill;
  logic             s1Ovf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Sign <= 1'b0;
      s1Sig  <= '0;
      s1Sh   <= '0;
      s1Kill <= 1'b1;
      s1Ovf  <= 1'b0;
    end else if (stb.s1Load) begin
      s1Sign <= signBit;
      s1Sig  <= {~isSub, fracField};
      s1Sh   <= shNext;
      s1Kill <= killNext;
      s1Ovf  <= ovfNext;
    end
  end

  // ---------------- stage 2: shift and negate ----------------
  logic [OUT_W-1:0] magWord;
  logic [OUT_W-1:0] resWord;

  always_comb begin
    magWord = OUT_W'((WIDE_W'(s1Sig) << s1Sh) >> SIG_W);
    if (s1Kill)
      resWord = '0;
    else if (s1Sign)
      resWord = -magWord;
    else
      resWord = magWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      outOvf  <= 1'b0;
    end else if (stb.s2Load) begin
      outData <= resWord;
      outOvf  <= s1Ovf;
    end
  end

  // R6
  inf_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s1Load && (&inData[FRAC_W +: EXP_W])) |=> s1Ovf);

  // R3
  sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s2Load && !s1Sign) |=> !outData[OUT_W-1]);

  // R7
  zero_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s1Load && (inData[IN_W-2:0] == '0)) |=> (s1Kill && !s1Ovf));

endmodule

// File: rtl/flt2fix_align.sv
module flt2fix_align
  import flt2fix_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MSB_W  = 1,
  parameter int LSB_W  = -50,
  localparam int IN_W  = 1 + EXP_W + FRAC_W,
  localparam int OUT_W = MSB_W - LSB_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [OUT_W-1:0] outData,
  output logic             outOvf
);

  stageStrobe_t stb;

  flt2fix_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  flt2fix_dp #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .MSB_W  (MSB_W),
    .LSB_W  (LSB_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .outData (outData),
    .outOvf  (outOvf)
  );

  // R6
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOvf) |-> (outData == '0));

endmodule

// File: tb/flt2fix_align_tb.sv
module flt2fix_align_tb;

  localparam int MSB   = 1;
  localparam int LSB   = -50;
  localparam int OUT_W = MSB - LSB + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [31:0]      inData = '0;
  logic             outValid;
  logic [OUT_W-1:0] outData;
  logic             outOvf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [OUT_W:0] expQ[$];
  string          reqQ[$];

  always #2 clk = ~clk;

  flt2fix_align #(.MSB_W(MSB), .LSB_W(LSB)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData),
    .outOvf   (outOvf)
  );

  // real-number reference: {ovf, word}
  function automatic logic [OUT_W:0] refModel(input logic [31:0] b);
    logic [7:0]       e;
    real              mant;
    real              mag;
    longint           v;
    logic [OUT_W-1:0] w;
    e = b[30:23];
    if (e == 8'hFF) return {1'b1, {OUT_W{1'b0}}};
    mant = ((e == 8'd0) ? 0.0 : 1.0) + real'(b[22:0]) / 8388608.0;
    mag  = mant * (2.0 ** real'(((e == 8'd0) ? -126 : int'(e) - 127)));
    if (mag >= 2.0 ** real'(MSB)) return {1'b1, {OUT_W{1'b0}}};
    v = longint'($floor(mag * (2.0 ** real'(-LSB))));
    if (b[31]) v = -v;
    w = v[OUT_W-1:0];
    return {1'b0, w};
  endfunction

  task automatic send(input logic [31:0] b, input string req);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    expQ.push_back(refModel(b));
    reqQ.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = 32'hDEAD_BEEF;
    end
  endtask

  // monitor
  initial begin
    logic [OUT_W:0] exp;
    string          req;
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected result ovf=%0b data=%h, expected none", outOvf, outData);
        end else begin
          exp = expQ.pop_front();
          req = reqQ.pop_front();
          if ({outOvf, outData} !== exp) begin
            errors++;
            $display("FAIL %s: ovf=%0b data=%h, expected ovf=%0b data=%h",
                     req, outOvf, outData, exp[OUT_W], exp[OUT_W-1:0]);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    repeat (4) @(negedge clk);
    // R8: reset state
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R8: outValid=%0b during reset, expected 0", outValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R8: outValid=%0b after reset, expected 0", outValid);
    end

    // R1: in-range positives
    send(32'h3F80_0000, "R1");   // 1.0
    send(32'h3FC0_0000, "R1");   // 1.5
    send(32'h3F40_0000, "R1");   // 0.75
    send(32'h3FFF_FFFF, "R1");   // just under 2.0
    send(32'h3DCC_CCCD, "R1");   // 0.1
    // R3: negatives
    send(32'hBF80_0000, "R3");
    send(32'hBE99_999A, "R3");
    send(32'hBFFF_FFFF, "R3");
    idle(3);
    // R6: out of range and specials
    send(32'h4000_0000, "R6");   // 2.0
    send(32'hC000_0000, "R6");   // -2.0
    send(32'h4049_0FDB, "R6");   // pi
    send(32'h7F80_0000, "R6");   // +inf
    send(32'hFF80_0000, "R6");   // -inf
    send(32'h7FC0_0000, "R6");   // NaN
    // R7: zeros
    send(32'h0000_0000, "R7");
    send(32'h8000_0000, "R7");
    idle(1);
    // R4: subnormals
    send(32'h0000_0001, "R4");
    send(32'h807F_FFFF, "R4");
    // R5: bottom of the grid
    send(32'h2680_0000, "R5");   // 2^-50
    send(32'h26C0_0000, "R5");   // 1.5*2^-50
    send(32'hA6C0_0000, "R5");   // -1.5*2^-50
    send(32'h2600_0000, "R5");   // 2^-51
    send(32'h2EDB_E6FF, "R5");   // ~1e-10
    idle(2);

    // R2: streamed varied exponents with gaps
    for (int i = 0; i < 300; i++) begin
      logic [7:0] ex;
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      ex = 8'(60 + (seed[15:8] % 71));
      send({seed[31], ex, seed[22:0]}, "R2");
      if (seed[3:0] == 4'd0) idle(int'(seed[5:4]) + 1);
    end
    idle(6);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule